// File: doc/BRIEF.md
# Core-Cycle Memory Sequencer

This block lets a processor core designed around destructive-read magnetic core storage run on an ordinary synchronous RAM. Each memory reference is carried out as two timed halves. In the read half the addressed word is fetched into the buffer register and the location is zeroed. In the write half the location is restored by merging its current contents with the buffer using OR. Because the location was zeroed just before, it ends up holding exactly the buffer value. Words and addresses are 12 bits wide.

The processor starts a reference with a one-cycle request. The request carries the address, a direction, write data, and two qualifiers: "increment-and-skip" and "indirect (defer) cycle". When the reference is an increment-and-skip, or an indirect cycle that lands on one of the auto-index locations (octal 0010 to 0017 by default), the buffer is incremented modulo 4096 during the read half. The incremented value is what is restored. The skip decision itself stays in the processor.

An optional fast mode removes the half that a plain reference does not need. A plain read skips the clear and the restore. A plain write skips the pre-read and clear. Any reference that modifies the word still runs both halves.

Top module: `coremem_seq`

## Requirements
- R1: After reset, busy_o and done_o are low and both ma_o and mb_o read zero.
- R2: A request is taken only while the block is idle; ma_o then holds the request address until the cycle ends, and a request raised while busy is ignored (ma_o unchanged, no extra cycle started).
- R3: A plain read in full mode keeps busy_o high for 2*HALF_TICKS clocks, returns the stored word on mb_o and leaves the stored word unchanged.
- R4: The read half of a full-mode cycle zeroes the location and the write half stores old contents OR buffer, so a full-mode write leaves exactly wdata_i in the location whatever it held before.
- R5: A read with isz_i set returns the stored word plus one modulo 4096 on mb_o and stores that value, so 7777 (octal) becomes 0000.
- R6: A read with defer_i set increments only when the address lies in 0010..0017 (octal); at 0007 and 0020 it behaves as a plain read.
- R7: In fast mode a plain read lasts HALF_TICKS clocks, returns the stored word and performs no RAM write.
- R8: In fast mode a write lasts HALF_TICKS clocks and stores wdata_i.
- R9: In fast mode a read that increments (R5 or R6) still lasts 2*HALF_TICKS clocks and stores the incremented word.
- R10: done_o is a one-clock pulse in the first idle clock after each cycle, when busy_o has just fallen.
- R11: mb_o holds the buffer from the end of the read half, through the write half, and until the next cycle loads it again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Start a memory reference (taken when idle) |
| wr_i | input | 1 | 1: write wdata_i, 0: read |
| addr_i | input | 12 | Referenced word address |
| wdata_i | input | 12 | Data for a write reference |
| isz_i | input | 1 | Reference belongs to an increment-and-skip instruction |
| defer_i | input | 1 | Reference is an indirect (defer) cycle |
| fast_i | input | 1 | Drop the unneeded half on plain references |
| busy_o | output | 1 | A cycle is in progress |
| done_o | output | 1 | One-clock end-of-cycle strobe |
| ma_o | output | 12 | Memory address register |
| mb_o | output | 12 | Memory buffer register |

## Verification
The assertions watch the per-cycle rules. done_o lasts a single clock and follows a busy period. The address register is frozen while busy. The buffer does not move during the write half. The location reads back as zero at the start of a full-mode write half, and a shortened plain read never writes the RAM. Whether the right value reaches the buffer and the RAM, which references count as auto-index, the 7777-to-0000 wrap, and how long each kind of cycle runs can only be shown by the bench. It compares read-backs and measured busy lengths against its own model of memory.

// File: rtl/coremem_pkg.sv
package coremem_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RD   = 2'd1,
      ST_WR   = 2'd2
   } cm_state_e;

endpackage

// File: rtl/coremem_ram.sv
module coremem_ram #(
   parameter int DATA_W = 12,
   parameter int MEM_AW = 10
) (
   input  logic              clk,
   input  logic [MEM_AW-1:0] addr,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << MEM_AW;

   logic [DATA_W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[addr] <= wdata;
      rdata <= store[addr];
   end
endmodule

// File: rtl/coremem_autoidx.sv
module coremem_autoidx #(
   parameter int ADDR_W     = 12,
   parameter int AIDX_BASE  = 8,
   parameter int AIDX_COUNT = 8
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              isz,
   input  logic              defer,
   output logic              bump
);
   localparam bit POW2    = (AIDX_COUNT & (AIDX_COUNT - 1)) == 0;
   localparam bit ALIGNED = (AIDX_BASE % AIDX_COUNT) == 0;

   logic in_window;

   generate
      if (POW2 && ALIGNED) begin : g_mask
         localparam logic [ADDR_W-1:0] MASK = ~ADDR_W'(AIDX_COUNT - 1);
         assign in_window = (addr & MASK) == ADDR_W'(AIDX_BASE);
      end else begin : g_range
         assign in_window = (addr >= ADDR_W'(AIDX_BASE)) &&
                            (addr <= ADDR_W'(AIDX_BASE + AIDX_COUNT - 1));
      end
   endgenerate

   assign bump = isz | (defer & in_window);
endmodule

// File: rtl/coremem_halftimer.sv
module coremem_halftimer #(
   parameter int HALF_TICKS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic t_first,
   output logic t_second,
   output logic t_last
);
   localparam int CW = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt <= '0;
      else if (restart) cnt <= '0;
      else              cnt <= cnt + CW'(1);
   end

   assign t_first  = (cnt == '0);
   assign t_second = (cnt == CW'(1));
   assign t_last   = (cnt == CW'(HALF_TICKS - 1));
endmodule

// File: rtl/coremem_seq.sv
module coremem_seq
   import coremem_pkg::*;
#(
   parameter int DATA_W     = 12,
   parameter int ADDR_W     = 12,
   parameter int MEM_AW     = 10,
   parameter int HALF_TICKS = 4,
   parameter bit FAST_EN    = 1'b1,
   parameter int AIDX_BASE  = 8,
   parameter int AIDX_COUNT = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              isz_i,
   input  logic              defer_i,
   input  logic              fast_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [ADDR_W-1:0] ma_o,
   output logic [DATA_W-1:0] mb_o
);
   generate
      if (HALF_TICKS < 2) begin : g_bad_half
         $error("HALF_TICKS must be at least 2");
      end
      if (MEM_AW > ADDR_W) begin : g_bad_mem
         $error("MEM_AW may not exceed ADDR_W");
      end
      if (AIDX_BASE + AIDX_COUNT > (1 << ADDR_W)) begin : g_bad_aidx
         $error("auto-index window exceeds the address space");
      end
   endgenerate

   cm_state_e         st;
   logic [ADDR_W-1:0] ma_q;
   logic [DATA_W-1:0] mb_q;
   logic              wr_q, inc_q, short_q, merge_q, done_q;
   logic              accept, bump, fast_eff, fast_wr, short_rd;
   logic              t_first, t_second, t_last, restart;
   logic              ram_we;
   logic [DATA_W-1:0] ram_wdata, ram_rdata;

   generate
      if (FAST_EN) begin : g_fast
         assign fast_eff = fast_i;
      end else begin : g_nofast
         assign fast_eff = 1'b0;
      end
   endgenerate

   coremem_autoidx #(
      .ADDR_W    (ADDR_W),
      .AIDX_BASE (AIDX_BASE),
      .AIDX_COUNT(AIDX_COUNT)
   ) u_aidx (
      .addr (addr_i),
      .isz  (isz_i),
      .defer(defer_i),
      .bump (bump)
   );

   assign accept   = (st == ST_IDLE) && req_i;
   assign fast_wr  = fast_eff && wr_i;
   assign short_rd = fast_eff && !wr_i && !bump;
   assign restart  = (st == ST_IDLE) || t_last;

   coremem_halftimer #(.HALF_TICKS(HALF_TICKS)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .t_first (t_first),
      .t_second(t_second),
      .t_last  (t_last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         ma_q    <= '0;
         mb_q    <= '0;
         wr_q    <= 1'b0;
         inc_q   <= 1'b0;
         short_q <= 1'b0;
         merge_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (accept) begin
                  ma_q    <= addr_i;
                  wr_q    <= wr_i;
                  inc_q   <= bump && !wr_i;
                  short_q <= short_rd;
                  merge_q <= !fast_wr;
                  if (wr_i) mb_q <= wdata_i;
                  st <= fast_wr ? ST_WR : ST_RD;
               end
            end
            ST_RD: begin
               if (t_second && !wr_q) mb_q <= ram_rdata + DATA_W'(inc_q);
               if (t_last) begin
                  if (short_q) begin
                     st     <= ST_IDLE;
                     done_q <= 1'b1;
                  end else begin
                     st <= ST_WR;
                  end
               end
            end
            ST_WR: begin
               if (t_last) begin
                  st     <= ST_IDLE;
                  done_q <= 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // Read half, second tick: zero the location. Write half, second tick:
   // restore (current OR buffer) or, after a skipped clear, the buffer alone.
   always_comb begin
      ram_we    = 1'b0;
      ram_wdata = '0;
      if (st == ST_RD && t_second && !short_q) begin
         ram_we = 1'b1;
      end else if (st == ST_WR && t_second) begin
         ram_we    = 1'b1;
         ram_wdata = merge_q ? (ram_rdata | mb_q) : mb_q;
      end
   end

   coremem_ram #(.DATA_W(DATA_W), .MEM_AW(MEM_AW)) u_ram (
      .clk  (clk),
      .addr (ma_q[MEM_AW-1:0]),
      .we   (ram_we),
      .wdata(ram_wdata),
      .rdata(ram_rdata)
   );

   assign busy_o = (st != ST_IDLE);
   assign done_o = done_q;
   assign ma_o   = ma_q;
   assign mb_o   = mb_q;

   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_done_after_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o)));

   p_ma_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(ma_o));

   p_mb_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WR && $past(st) == ST_WR) |-> $stable(mb_q));

   p_cleared_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WR && t_first && merge_q) |=> (ram_rdata == '0));

   p_short_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RD && short_q) |-> !ram_we);
endmodule

// File: tb/coremem_seq_bench.sv
`timescale 1ns/1ps
module coremem_seq_bench;
   localparam int H = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_i = 1'b0, wr_i = 1'b0, isz_i = 1'b0, defer_i = 1'b0, fast_i = 1'b0;
   logic [11:0] addr_i = '0, wdata_i = '0;
   logic        busy_o, done_o;
   logic [11:0] ma_o, mb_o;

   int total = 0;
   int bad   = 0;
   logic [11:0] model [1024];

   always #2.5 clk = ~clk;

   coremem_seq #(.HALF_TICKS(H)) u_coremem_seq (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_i(wr_i), .addr_i(addr_i),
      .wdata_i(wdata_i), .isz_i(isz_i), .defer_i(defer_i), .fast_i(fast_i),
      .busy_o(busy_o), .done_o(done_o), .ma_o(ma_o), .mb_o(mb_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0o expected=%0o", req, act, exp);
      end
   endtask

   function automatic bit exp_bump(bit wr, bit isz, bit defer, logic [11:0] a);
      return !wr && (isz || (defer && a >= 12'o10 && a <= 12'o17));
   endfunction

   function automatic int exp_len(bit wr, bit isz, bit defer, bit fast, logic [11:0] a);
      return (fast && !exp_bump(wr, isz, defer, a)) ? H : 2 * H;
   endfunction

   task automatic issue(input bit wr, input logic [11:0] a, input logic [11:0] d,
                        input bit isz, input bit defer, input bit fast,
                        output int len, output logic [11:0] mb);
      @(negedge clk);
      req_i = 1'b1; wr_i = wr; addr_i = a; wdata_i = d;
      isz_i = isz; defer_i = defer; fast_i = fast;
      @(negedge clk);
      req_i = 1'b0;
      len = 0;
      while (!done_o && len < 100) begin
         if (busy_o) len++;
         @(negedge clk);
      end
      mb = mb_o;
      @(negedge clk);
      chk(!done_o, "R10 done width", done_o, 0);
   endtask

   // Run one reference, compare buffer and length with the model, update model.
   task automatic op(input string req, input bit wr, input logic [11:0] a,
                     input logic [11:0] d, input bit isz, input bit defer, input bit fast);
      int          len;
      logic [11:0] mb, exp_mb;
      bit          b;
      b      = exp_bump(wr, isz, defer, a);
      exp_mb = wr ? d : model[a[9:0]] + 12'(b);
      issue(wr, a, d, isz, defer, fast, len, mb);
      chk(mb == exp_mb, req, mb, exp_mb);
      chk(len == exp_len(wr, isz, defer, fast, a), {req, " length"}, len,
          exp_len(wr, isz, defer, fast, a));
      if (wr || b) model[a[9:0]] = exp_mb;
   endtask

   task automatic readback(input string req, input logic [11:0] a);
      op(req, 1'b0, a, 12'o0, 1'b0, 1'b0, 1'b0);
   endtask

   initial begin
      #(5.0 * 150000);
      chk(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int          len;
      logic [11:0] mb, hold_ma;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!busy_o, "R1 busy", busy_o, 0);
      chk(!done_o, "R1 done", done_o, 0);
      chk(ma_o == 0, "R1 ma", ma_o, 0);
      chk(mb_o == 0, "R1 mb", mb_o, 0);
      rst_n = 1'b1;

      // R4: full-mode writes initialise locations 0..63
      for (int i = 0; i < 64; i++) op("R4 init write", 1'b1, 12'(i), 12'($urandom), 0, 0, 0);
      // R4: overwrite all-ones with a sparse value; OR without clear would keep ones
      op("R4 set ones", 1'b1, 12'o5, 12'o7777, 0, 0, 0);
      op("R4 overwrite", 1'b1, 12'o5, 12'o0101, 0, 0, 0);
      readback("R4 exact value", 12'o5);
      // R3 plain read leaves word unchanged
      readback("R3 plain read", 12'o30);
      readback("R3 reread", 12'o30);

      // R5 increment-and-skip with wrap
      op("R5 set 7777", 1'b1, 12'o12, 12'o7777, 0, 0, 0);
      op("R5 isz wrap", 1'b0, 12'o12, 0, 1, 0, 0);
      readback("R5 wrapped stored", 12'o12);
      op("R5 isz plain", 1'b0, 12'o40, 0, 1, 0, 0);
      readback("R5 stored", 12'o40);

      // R6 auto-index window edges
      op("R6 defer 0007", 1'b0, 12'o7, 0, 0, 1, 0);
      readback("R6 0007 untouched", 12'o7);
      op("R6 defer 0010", 1'b0, 12'o10, 0, 0, 1, 0);
      readback("R6 0010 bumped", 12'o10);
      op("R6 defer 0017", 1'b0, 12'o17, 0, 0, 1, 0);
      readback("R6 0017 bumped", 12'o17);
      op("R6 defer 0020", 1'b0, 12'o20, 0, 0, 1, 0);
      readback("R6 0020 untouched", 12'o20);
      op("R6 set 7777", 1'b1, 12'o14, 12'o7777, 0, 0, 0);
      op("R6 defer wrap", 1'b0, 12'o14, 0, 0, 1, 0);
      readback("R6 wrapped stored", 12'o14);

      // R7, R8, R9 fast mode
      op("R7 fast read", 1'b0, 12'o33, 0, 0, 0, 1);
      readback("R7 unchanged", 12'o33);
      op("R8 fast write", 1'b1, 12'o34, 12'o4321, 0, 0, 1);
      readback("R8 stored", 12'o34);
      op("R9 fast isz", 1'b0, 12'o35, 0, 1, 0, 1);
      readback("R9 isz stored", 12'o35);
      op("R9 fast defer 0011", 1'b0, 12'o11, 0, 0, 1, 1);
      readback("R9 defer stored", 12'o11);
      op("R7 fast defer 0021", 1'b0, 12'o21, 0, 0, 1, 1);

      // R2 request while busy is ignored
      @(negedge clk);
      req_i = 1'b1; wr_i = 1'b0; addr_i = 12'o25; isz_i = 0; defer_i = 0; fast_i = 0;
      @(negedge clk);
      hold_ma = ma_o;
      chk(hold_ma == 12'o25, "R2 ma captured", hold_ma, 12'o25);
      wr_i = 1'b1; addr_i = 12'o26; wdata_i = 12'o1111;
      len = 0;
      while (!done_o && len < 100) begin
         chk(ma_o == 12'o25, "R2 ma stable", ma_o, 12'o25);
         len++;
         @(negedge clk);
      end
      req_i = 1'b0;
      @(negedge clk);
      chk(!busy_o, "R2 no extra cycle", busy_o, 0);
      readback("R2 other word intact", 12'o26);

      // R11 buffer holds while idle
      op("R11 load", 1'b0, 12'o27, 0, 0, 0, 0);
      mb = mb_o;
      repeat (5) @(negedge clk);
      chk(mb_o == mb, "R11 held", mb_o, mb);

      // Random mix
      for (int i = 0; i < 300; i++) begin
         bit          w, z, f, df;
         logic [11:0] a;
         a  = 12'($urandom_range(63));
         w  = ($urandom_range(3) == 0);
         z  = ($urandom_range(4) == 0);
         df = ($urandom_range(2) == 0);
         f  = $urandom_range(1);
         op("R3/R5/R6/R7/R8/R9 random", w, a, 12'($urandom), z, df, f);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule